// File: doc/BRIEF.md
# Abstract Register Access Sequencer

This block turns one debug "access register" command into the short list of RV instruction words that a halted hart runs from the abstract-command area. The debug front end presents the register number, a size code, transfer, write and post-execute flags, the program-buffer length and the selected hart, then pulses `start`. The sequencer validates the request. It then writes one instruction word per clock into the abstract area through a word-indexed write port. It finishes with a one-cycle `done` pulse that carries the command-error code and, on success, a go request for the selected hart.

Three kinds of register are handled:
- Integer registers move through a single load or store against the data area at address 0x380, addressed from register zero.
- Floating-point registers work the same way, using the floating-point load and store opcodes.
- CSRs use a four-word sequence. It parks S0 in the debug-scratch CSR (0x7B2), moves the value through S0, and then restores S0.

Every sequence ends with one of two words. One is a breakpoint. The other is a jump with link register zero that lands on the first word of the program buffer, which sits directly below the data area.

Top module: `abs_cmd_builder`

## Requirements
- R1: After reset, `mem_we`, `done` and `go_set` are low and `cmd_err` is 0.
- R2: With transfer set, register numbers 0x1000..0x101F address integer register (number − 0x1000). A write emits load x(n), 0x380(x0). A read emits store x(n), 0x380(x0). Opcodes are 0x03 and 0x23.
- R3: With transfer set, register numbers 0x1020..0x103F address floating-point register (number − 0x1020). Opcodes are 0x07 for load and 0x27 for store, with the same addressing as R2.
- R4: A number below 0x1000, when `progbuf_words` < 2, is a CSR access of four words. Word 0 is csrrw x0,0x7B2,x8. Words 1 and 2 are either "load x8 from 0x380; csrrw x0,csr,x8" for a write, or "csrrs x8,csr,x0; store x8 to 0x380" for a read. Word 3 is csrrs x8,0x7B2,x0.
- R5: With transfer set, a CSR number when `progbuf_words` ≥ 2, or any number ≥ 0x1040, ends with `cmd_err` = 2. No word is written and no go is raised.
- R6: Size code 2 selects the word forms (funct3 = 2). Size code 3 selects the doubleword forms (funct3 = 3). Any other size code with transfer set gives `cmd_err` = 2, no writes and no go.
- R7: The last word is a breakpoint (0x00100073) when post-execute is clear. When post-execute is set, it is a JAL with rd = x0 and byte offset 20 − 4·i, where i is its index.
- R8: With transfer clear, the register number and size are not checked. The sequence is only the final word, at index 0.
- R9: `done` pulses for one cycle, on the cycle after the last word write, or on the cycle after `start` when the command fails. On success, `go_set` is one-hot at bit `hart_sel` during that cycle. Otherwise `go_set` is zero.
- R10: Words are written one per clock on consecutive cycles, with `mem_idx` running up from 0.
- R11: A `start` pulse arriving while a sequence is in progress is ignored.
- R12: `cmd_err` holds the result of the last command until the next accepted `start`. A successful command leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only when idle |
| regno | input | 16 | Register number |
| size | input | 3 | Access size code |
| transfer | input | 1 | Move data to or from the register |
| write | input | 1 | 1 = data area to register, 0 = register to data area |
| postexec | input | 1 | Continue into the program buffer afterwards |
| progbuf_words | input | PBW | Program buffer length in words |
| hart_sel | input | HSW | Selected hart |
| mem_we | output | 1 | Abstract-area word write strobe |
| mem_idx | output | IW | Word index being written |
| mem_wdata | output | 32 | Instruction word |
| cmd_err | output | 3 | Command error code (0 ok, 2 not supported) |
| go_set | output | NHARTS | Go request, one bit per hart |
| done | output | 1 | Command finished pulse |

## Verification
The bench checks exact word values for every template and both size codes. A swapped funct3, a wrong rs2/rd position or a misplaced S-type immediate would show up as a word mismatch.

It covers the range edges 0x101F, 0x1020 and 0x1040, and the CSR case at a program buffer of exactly 2 words. An off-by-one range compare would emit words where an error is due, or reject a valid register.

Jump offsets are checked at indices 0, 1 and 4. A design that ignores the word index in the offset would jump to the wrong buffer slot. The bench also probes `start` during a run, clears the error on a following good command, and checks transfer-clear with junk fields. These catch a restart that corrupts the sequence, a sticky error, and a block that validates fields it should skip.

// File: rtl/abs_cmd_builder.sv
module abs_cmd_builder #(
  parameter int NHARTS = 4,
  parameter int PBW = 5,
  parameter int ABS_WORDS = 5,
  parameter logic [11:0] DATA_BASE = 12'h380,
  parameter logic [11:0] SCRATCH_CSR = 12'h7B2,
  localparam int HSW = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  localparam int IW = $clog2(ABS_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       regno,
  input  logic [2:0]        size,
  input  logic              transfer,
  input  logic              write,
  input  logic              postexec,
  input  logic [PBW-1:0]    progbuf_words,
  input  logic [HSW-1:0]    hart_sel,
  output logic              mem_we,
  output logic [IW-1:0]     mem_idx,
  output logic [31:0]       mem_wdata,
  output logic [2:0]        cmd_err,
  output logic [NHARTS-1:0] go_set,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  typedef enum logic [1:0] {K_NONE, K_GPR, K_FPR, K_CSR} kind_t;

  localparam logic [6:0] OP_LD = 7'h03, OP_ST = 7'h23, OP_FLD = 7'h07,
                         OP_FST = 7'h27, OP_SYS = 7'h73, OP_JAL = 7'h6F;
  localparam logic [4:0] S0 = 5'd8, X0 = 5'd0;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2,
                                        logic [4:0] rs1, logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [31:0] enc_j(logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], X0, OP_JAL};
  endfunction

  st_t st;
  kind_t kind;
  logic [IW-1:0] idx, last;
  logic wr, dbl, post, failed;
  logic [11:0] rnum;
  logic [HSW-1:0] hart;

  wire is_gpr = regno[15:5] == 11'h080;
  wire is_fpr = regno[15:5] == 11'h081;
  wire is_csr = regno < 16'h1000 && progbuf_words < PBW'(2);
  wire size_ok = size == 3'd2 || size == 3'd3;
  wire bad = transfer && (!size_ok || !(is_gpr || is_fpr || is_csr));

  kind_t kind_n;
  always_comb begin
    if (!transfer) kind_n = K_NONE;
    else if (is_gpr) kind_n = K_GPR;
    else if (is_fpr) kind_n = K_FPR;
    else kind_n = K_CSR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind <= K_NONE;
      idx <= '0;
      last <= '0;
      wr <= 1'b0;
      dbl <= 1'b0;
      post <= 1'b0;
      failed <= 1'b0;
      rnum <= '0;
      hart <= '0;
      cmd_err <= 3'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          kind <= kind_n;
          idx <= '0;
          last <= (kind_n == K_NONE) ? IW'(0) : (kind_n == K_CSR) ? IW'(4) : IW'(1);
          wr <= write;
          dbl <= size[0];
          post <= postexec;
          rnum <= regno[11:0];
          hart <= hart_sel;
          failed <= bad;
          cmd_err <= bad ? 3'd2 : 3'd0;
          st <= bad ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (idx == last) st <= S_FIN;
          else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [2:0] f3m = {2'b01, dbl};
  wire [20:0] jmp_off = 21'(ABS_WORDS * 4) - {{(19-IW){1'b0}}, idx, 2'b00};
  wire [31:0] final_word = post ? enc_j(jmp_off) : 32'h0010_0073;

  always_comb begin
    mem_wdata = final_word;
    if (idx != last) begin
      case (kind)
        K_GPR: mem_wdata = wr ? enc_i(DATA_BASE, X0, f3m, rnum[4:0], OP_LD)
                              : enc_s(DATA_BASE, rnum[4:0], X0, f3m, OP_ST);
        K_FPR: mem_wdata = wr ? enc_i(DATA_BASE, X0, f3m, rnum[4:0], OP_FLD)
                              : enc_s(DATA_BASE, rnum[4:0], X0, f3m, OP_FST);
        K_CSR: case (idx)
          IW'(0): mem_wdata = enc_i(SCRATCH_CSR, S0, 3'b001, X0, OP_SYS);
          IW'(1): mem_wdata = wr ? enc_i(DATA_BASE, X0, f3m, S0, OP_LD)
                                 : enc_i(rnum, X0, 3'b010, S0, OP_SYS);
          IW'(2): mem_wdata = wr ? enc_i(rnum, S0, 3'b001, X0, OP_SYS)
                                 : enc_s(DATA_BASE, S0, X0, f3m, OP_ST);
          default: mem_wdata = enc_i(SCRATCH_CSR, X0, 3'b010, S0, OP_SYS);
        endcase
        default: mem_wdata = final_word;
      endcase
    end
  end

  assign mem_we = st == S_RUN;
  assign mem_idx = idx;
  assign done = st == S_FIN;
  assign go_set = (done && !failed) ? (NHARTS'(1) << hart) : '0;
endmodule

module abs_cmd_builder_chk #(
  parameter int NHARTS = 4,
  parameter int ABS_WORDS = 5,
  localparam int IW = $clog2(ABS_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [IW-1:0]     mem_idx,
  input logic [2:0]        cmd_err,
  input logic [NHARTS-1:0] go_set,
  input logic              done
);
  assert_go_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go_set != '0) |-> done);
  assert_go_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_set));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_no_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_err != 3'd0) |-> go_set == '0);
  assert_no_write_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !done);
  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_idx < IW'(ABS_WORDS));
  assert_first_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> mem_idx == '0);
  assert_idx_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_idx == $past(mem_idx) + 1'b1);
  assert_contiguous_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_we || done));
endmodule

bind abs_cmd_builder abs_cmd_builder_chk #(.NHARTS(NHARTS), .ABS_WORDS(ABS_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_idx(mem_idx),
  .cmd_err(cmd_err), .go_set(go_set), .done(done));

// File: tb/abs_cmd_builder_tb.sv
module abs_cmd_builder_tb;
  logic clk = 0, rst_n = 0, start = 0, transfer = 0, write = 0, postexec = 0;
  logic [15:0] regno = 0;
  logic [2:0] size = 0;
  logic [4:0] progbuf_words = 0;
  logic [1:0] hart_sel = 0;
  logic mem_we, done;
  logic [2:0] mem_idx, cmd_err;
  logic [31:0] mem_wdata;
  logic [3:0] go_set;

  int n_chk = 0, n_bad = 0;
  int nwr, last_cyc, done_cyc;
  logic [31:0] words [0:7];
  logic [3:0] got_go;
  logic [2:0] got_err;

  always #2 clk = ~clk;

  abs_cmd_builder u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [15:0] r, logic [2:0] sz, logic tr, logic wrt, logic pe,
                     logic [4:0] pb, logic [1:0] h, bit poke);
    @(negedge clk);
    regno = r; size = sz; transfer = tr; write = wrt; postexec = pe;
    progbuf_words = pb; hart_sel = h; start = 1;
    @(negedge clk);
    start = 0;
    nwr = 0; last_cyc = -1; done_cyc = -1; got_go = 0; got_err = 0;
    for (int i = 0; i < 8; i++) words[i] = 32'hDEAD_BEEF;
    for (int c = 0; c < 20; c++) begin
      if (mem_we) begin
        words[mem_idx] = mem_wdata; nwr++; last_cyc = c;
      end
      if (done) begin
        done_cyc = c; got_go = go_set; got_err = cmd_err; break;
      end
      if (poke && c == 1) begin
        regno = 16'h1003; transfer = 1; write = 0; size = 3'd2; postexec = 0; start = 1;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic t_reset;
    chk("R1 we", mem_we, 0); chk("R1 done", done, 0);
    chk("R1 go", go_set, 0); chk("R1 err", cmd_err, 0);
  endtask

  task automatic t_gpr;
    run(16'h1005, 3'd2, 1, 1, 0, 5'd0, 2'd1, 0);
    chk("R2 count", nwr, 2); chk("R2 lw x5", words[0], 32'h38002283);
    chk("R7 ebreak", words[1], 32'h00100073);
    chk("R9 go", got_go, 4'b0010); chk("R9 done timing", done_cyc, last_cyc + 1);
    chk("R12 err", got_err, 0);
    run(16'h101F, 3'd3, 1, 0, 1, 5'd3, 2'd3, 0);
    chk("R2 sd x31", words[0], 32'h39F03023); chk("R7 jal idx1", words[1], 32'h0100006F);
    chk("R9 go3", got_go, 4'b1000);
  endtask

  task automatic t_fpr;
    run(16'h1022, 3'd3, 1, 1, 1, 5'd0, 2'd0, 0);
    chk("R3 fld f2", words[0], 32'h38003107); chk("R3 jal", words[1], 32'h0100006F);
    run(16'h1020, 3'd2, 1, 0, 0, 5'd8, 2'd2, 0);
    chk("R3 fsw f0", words[0], 32'h38002027); chk("R3 count", nwr, 2);
    chk("R3 go", got_go, 4'b0100);
  endtask

  task automatic t_csr;
    run(16'h0300, 3'd2, 1, 1, 1, 5'd1, 2'd0, 0);
    chk("R4 count", nwr, 5); chk("R4 save", words[0], 32'h7B241073);
    chk("R4 lw s0", words[1], 32'h38002403); chk("R4 csrw", words[2], 32'h30041073);
    chk("R4 restore", words[3], 32'h7B202473); chk("R7 jal idx4", words[4], 32'h0040006F);
    chk("R9 go", got_go, 4'b0001);
    run(16'h07A0, 3'd3, 1, 0, 0, 5'd0, 2'd2, 0);
    chk("R4 csrr", words[1], 32'h7A002473); chk("R4 sd s0", words[2], 32'h38803023);
    chk("R4 ebreak", words[4], 32'h00100073); chk("R4 done timing", done_cyc, last_cyc + 1);
  endtask

  task automatic t_errors;
    run(16'h0300, 3'd2, 1, 1, 0, 5'd2, 2'd1, 0);
    chk("R5 pb2 err", got_err, 2); chk("R5 pb2 writes", nwr, 0);
    chk("R5 pb2 go", got_go, 0); chk("R9 err done timing", done_cyc, 0);
    run(16'h1040, 3'd2, 1, 0, 0, 5'd0, 2'd1, 0);
    chk("R5 0x1040 err", got_err, 2); chk("R5 0x1040 writes", nwr, 0);
    run(16'h1001, 3'd1, 1, 1, 0, 5'd0, 2'd1, 0);
    chk("R6 size1 err", got_err, 2); chk("R6 size1 go", got_go, 0);
    run(16'h0300, 3'd4, 1, 1, 0, 5'd0, 2'd1, 0);
    chk("R6 size4 csr err", got_err, 2); chk("R6 size4 writes", nwr, 0);
    @(negedge clk); chk("R12 err held", cmd_err, 2);
    run(16'h1001, 3'd2, 1, 0, 0, 5'd0, 2'd1, 0);
    chk("R12 err cleared", got_err, 0); chk("R6 sw x1", words[0], 32'h38102023);
  endtask

  task automatic t_notransfer;
    run(16'hFFFF, 3'd7, 0, 1, 1, 5'd9, 2'd2, 0);
    chk("R8 count", nwr, 1); chk("R8 jal idx0", words[0], 32'h0140006F);
    chk("R8 err", got_err, 0); chk("R8 go", got_go, 4'b0100);
    run(16'h2000, 3'd0, 0, 0, 0, 5'd0, 2'd0, 0);
    chk("R8 ebreak", words[0], 32'h00100073); chk("R8 count2", nwr, 1);
  endtask

  task automatic t_busy;
    run(16'h0305, 3'd2, 1, 0, 0, 5'd0, 2'd1, 1);
    chk("R11 count", nwr, 5); chk("R11 word1", words[1], 32'h30502473);
    chk("R11 word2", words[2], 32'h38802023); chk("R11 go", got_go, 4'b0010);
    @(negedge clk); chk("R11 no restart we", mem_we, 0);
    @(negedge clk); chk("R11 no restart done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_gpr(); t_fpr(); t_csr(); t_errors(); t_notransfer(); t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule